// File: doc/BRIEF.md
# Word-Serial Multi-Word Fixed-Point Accumulator

This block keeps a running total in a wide signed fixed-point format. The total is built from several machine words and held in two's complement form, and each incoming operand of the same width is added to it. The adder is only one word wide, so an addition walks through the words one per clock. It starts at the least significant word and passes the carry upward. The carry out of the most significant word is dropped. Integer addition is associative, so the final total after any set of operands is the same whatever order they arrive in. This is the point of the block: a reduction of many real values converted to fixed point gives a result that repeats exactly from run to run.

Operands enter over a valid/ready handshake and are taken only while the block is idle. A synchronous clear empties the total and drops the sticky overflow flag. Each completed addition gives a one-cycle done pulse with its own overflow verdict. Overflow is judged on the sign bits of the two addends and the result. The sticky flag collects these verdicts until the next clear.

Word numbering: word 0 is the most significant word and holds the sign bit, and word N-1 is the least significant. The operand and sum vectors are packed with word 0 in the top bits, so each vector reads as a plain two's complement integer of N*W bits.

Top module: `mwacc_top`

## Requirements
- R1: After reset the sum is zero, the sticky flag and done pulse are low, and op_ready_o is high.
- R2: An operand is taken on a clock edge where op_valid_i and op_ready_o are both high. op_ready_o then stays low for exactly NUM_WORDS cycles. done_o is high for one cycle, in the cycle where op_ready_o returns.
- R3: When done_o rises, sum_o equals the previous sum plus the operand modulo 2^(NUM_WORDS*WORD_W). Words are added from word N-1 (least significant, bits [WORD_W-1:0]) up to word 0 (most significant). Each carry goes into the next more significant word, and a carry out of word 0 is lost.
- R4: done_ovf_o is high with done_o exactly when both addends have the same top bit and the result's top bit differs from it.
- R5: ovf_sticky_o rises with any addition whose overflow verdict is true and stays high until a clear.
- R6: A clear sets the whole sum to zero and drops the sticky flag on the next edge. A clear also abandons any addition in progress, and op_ready_o is low while clear_i is high.
- R7: Adding 1024 values made of 512 values and their exact negatives, in any shuffled order, leaves a sum of exactly zero with no overflow.
- R8: op_valid_i while op_ready_o is low has no effect. The operand offered then is never added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of sum and sticky flag |
| op_valid_i | input | 1 | Operand offered |
| op_ready_o | output | 1 | Block idle and able to take an operand |
| op_data_i | input | NUM_WORDS*WORD_W | Operand, word 0 in the top bits |
| sum_o | output | NUM_WORDS*WORD_W | Running sum, word 0 in the top bits |
| done_o | output | 1 | One-cycle pulse when an addition completes |
| done_ovf_o | output | 1 | Overflow verdict of the addition just completed |
| ovf_sticky_o | output | 1 | Sticky overflow flag |

## Verification
The bench drives carry chains that ripple through every word: +12 against -12, and 2^64-1 plus 1. A design that wired the carry to the wrong word, or processed the words from the wrong end, would leave stray bits or a missing 2^64 in the total. Both overflow directions are exercised (largest positive plus one, most negative plus minus one), together with a cancelling pair whose carry out of the top word must not be taken as overflow. A design that judged overflow from the carry would flag that pair. A clear in the middle of an addition and an operand offered while busy each check that nothing leaks into the total. A shuffled set of 1024 paired values must cancel to zero, and a lost carry anywhere would leave a nonzero residue.

// File: rtl/mwacc_pkg.sv
package mwacc_pkg;

    localparam int DEF_WORD_W    = 64;
    localparam int DEF_NUM_WORDS = 4;

    // Carry rule for one word lane. The wrapped result is compared with the
    // operand word. A result below it means the addition wrapped. A result
    // equal to it means the lane added nothing of its own, so the incoming
    // carry passes through.
    function automatic logic lane_carry(input logic [DEF_WORD_W-1:0] res,
                                        input logic [DEF_WORD_W-1:0] opw,
                                        input logic                  cin);
        if (res == opw) return cin;
        return (res < opw);
    endfunction

endpackage

// File: rtl/mwacc_word_add.sv
module mwacc_word_add #(
    parameter int WORD_W = mwacc_pkg::DEF_WORD_W
) (
    input  logic [WORD_W-1:0] acc_w_i,
    input  logic [WORD_W-1:0] opd_w_i,
    input  logic              cin_i,
    output logic [WORD_W-1:0] res_w_o,
    output logic              cout_o
);
    logic [WORD_W-1:0] res_w;

    always_comb begin
        res_w = acc_w_i + opd_w_i + {{(WORD_W-1){1'b0}}, cin_i};
        if (res_w == opd_w_i) cout_o = cin_i;
        else                  cout_o = (res_w < opd_w_i);
    end

    assign res_w_o = res_w;
endmodule

// File: rtl/mwacc_ovf_judge.sv
module mwacc_ovf_judge (
    input  logic acc_sign_i,
    input  logic opd_sign_i,
    input  logic res_sign_i,
    output logic ovf_o
);
    always_comb begin
        ovf_o = (acc_sign_i == opd_sign_i) && (res_sign_i != acc_sign_i);
    end
endmodule

// File: rtl/mwacc_top.sv
module mwacc_top #(
    parameter int WORD_W    = mwacc_pkg::DEF_WORD_W,
    parameter int NUM_WORDS = mwacc_pkg::DEF_NUM_WORDS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        op_valid_i,
    output logic                        op_ready_o,
    input  logic [NUM_WORDS*WORD_W-1:0] op_data_i,
    output logic [NUM_WORDS*WORD_W-1:0] sum_o,
    output logic                        done_o,
    output logic                        done_ovf_o,
    output logic                        ovf_sticky_o
);
    localparam int TOT_W = NUM_WORDS * WORD_W;
    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W-1:0] POS_LAST = IDX_W'(NUM_WORDS - 1);
    localparam logic [IDX_W-1:0] POS_ONE  = IDX_W'(1);

    typedef logic [NUM_WORDS-1:0][WORD_W-1:0] words_t;

    // Packed index p is significance: p = 0 is the least significant word.
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] pos;
        logic             carry;
        words_t           acc;
        words_t           opnd;
        logic             sticky;
        logic             done;
        logic             done_ovf;
    } state_t;

    state_t s_d, s_q;

    logic [WORD_W-1:0] lane_res;
    logic              lane_cout;
    logic              top_ovf;
    words_t            acc_upd;

    mwacc_word_add #(.WORD_W(WORD_W)) u_lane (
        .acc_w_i (s_q.acc[s_q.pos]),
        .opd_w_i (s_q.opnd[s_q.pos]),
        .cin_i   (s_q.carry),
        .res_w_o (lane_res),
        .cout_o  (lane_cout)
    );

    mwacc_ovf_judge u_judge (
        .acc_sign_i (s_q.acc[NUM_WORDS-1][WORD_W-1]),
        .opd_sign_i (s_q.opnd[NUM_WORDS-1][WORD_W-1]),
        .res_sign_i (lane_res[WORD_W-1]),
        .ovf_o      (top_ovf)
    );

    // Write-back of the lane result into the word under the cursor.
    for (genvar p = 0; p < NUM_WORDS; p++) begin : g_wb
        assign acc_upd[p] = (s_q.busy && (s_q.pos == IDX_W'(p))) ? lane_res
                                                                  : s_q.acc[p];
    end

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.done_ovf = 1'b0;
        if (clear_i) begin
            s_d.busy   = 1'b0;
            s_d.pos    = '0;
            s_d.carry  = 1'b0;
            s_d.acc    = '0;
            s_d.sticky = 1'b0;
        end else if (s_q.busy) begin
            s_d.acc   = acc_upd;
            s_d.carry = lane_cout;
            if (s_q.pos == POS_LAST) begin
                s_d.busy     = 1'b0;
                s_d.pos      = '0;
                s_d.done     = 1'b1;
                s_d.done_ovf = top_ovf;
                s_d.sticky   = s_q.sticky | top_ovf;
            end else begin
                s_d.pos = s_q.pos + POS_ONE;
            end
        end else if (op_valid_i) begin
            s_d.busy  = 1'b1;
            s_d.pos   = '0;
            s_d.carry = 1'b0;
            s_d.opnd  = words_t'(op_data_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign op_ready_o   = !s_q.busy && !clear_i;
    assign sum_o        = TOT_W'(s_q.acc);
    assign done_o       = s_q.done;
    assign done_ovf_o   = s_q.done_ovf;
    assign ovf_sticky_o = s_q.sticky;
endmodule

// File: rtl/mwacc_checker.sv
module mwacc_checker #(
    parameter int TOT_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic             op_valid_i,
    input logic             op_ready_o,
    input logic [TOT_W-1:0] sum_o,
    input logic             done_o,
    input logic             done_ovf_o,
    input logic             ovf_sticky_o
);
    // R2: after a taken operand the block is busy on the next cycle
    a_r2_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_ready_o) |=> !op_ready_o);

    // R2: done lasts a single cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: done coincides with ready returning, unless a clear masks ready
    a_r2_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |-> op_ready_o);

    // R4 / R5: an overflowing addition leaves the sticky flag set
    a_r4_ovf_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_ovf_o) |-> ovf_sticky_o);

    // R4: no overflow verdict without a completed addition
    a_r4_ovf_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_ovf_o |-> done_o);

    // R5: sticky holds until a clear
    a_r5_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky_o && !clear_i) |=> ovf_sticky_o);

    // R6: clear empties the sum and drops the flag
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (sum_o == '0) && !ovf_sticky_o);

    // R6: not ready while clearing
    a_r6_clear_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |-> !op_ready_o);

    // R8 / R3: an idle block with nothing offered keeps its sum
    a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready_o && !op_valid_i) |=> $stable(sum_o));
endmodule

bind mwacc_top mwacc_checker #(.TOT_W(TOT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (clear_i),
    .op_valid_i   (op_valid_i),
    .op_ready_o   (op_ready_o),
    .sum_o        (sum_o),
    .done_o       (done_o),
    .done_ovf_o   (done_ovf_o),
    .ovf_sticky_o (ovf_sticky_o)
);

// File: tb/mwacc_top_test.sv
module mwacc_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 64;
    localparam int NW = 4;
    localparam int TW = WW * NW;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          op_valid = 1'b0;
    logic [TW-1:0] op_data = '0;
    logic          op_ready;
    logic [TW-1:0] sum;
    logic          done;
    logic          done_ovf;
    logic          sticky;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    mwacc_top #(.WORD_W(WW), .NUM_WORDS(NW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clear),
        .op_valid_i   (op_valid),
        .op_ready_o   (op_ready),
        .op_data_i    (op_data),
        .sum_o        (sum),
        .done_o       (done),
        .done_ovf_o   (done_ovf),
        .ovf_sticky_o (sticky)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: plain wide integer arithmetic plus a busy countdown.
    logic [TW-1:0] m_sum = '0;
    logic [TW-1:0] m_op  = '0;
    int            m_cnt = 0;
    bit            m_sticky = 1'b0;
    bit            m_done = 1'b0;
    bit            m_dovf = 1'b0;

    always @(posedge clk) begin
        logic [TW-1:0] nxt;
        bit ov;
        if (!rst_n) begin
            m_sum = '0; m_cnt = 0; m_sticky = 1'b0; m_done = 1'b0; m_dovf = 1'b0;
        end else begin
            m_done = 1'b0;
            m_dovf = 1'b0;
            if (clear) begin
                m_sum = '0; m_sticky = 1'b0; m_cnt = 0;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    nxt = m_sum + m_op;
                    ov = (m_sum[TW-1] == m_op[TW-1]) && (nxt[TW-1] != m_sum[TW-1]);
                    m_sum = nxt;
                    m_done = 1'b1;
                    m_dovf = ov;
                    m_sticky = m_sticky | ov;
                end
            end else if (op_valid) begin
                m_op = op_data;
                m_cnt = NW;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare on every clock, a quarter period after the edge.
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !finished) begin
            chk(op_ready == ((m_cnt == 0) && !clear), "R2 ready", TW'(op_ready),
                TW'((m_cnt == 0) && !clear));
            chk(done == m_done, "R2 done pulse", TW'(done), TW'(m_done));
            if (m_done)
                chk(done_ovf == m_dovf, "R4 overflow verdict", TW'(done_ovf), TW'(m_dovf));
            chk(sticky == m_sticky, "R5 sticky flag", TW'(sticky), TW'(m_sticky));
            if (m_cnt == 0)
                chk(sum == m_sum, "R3 sum", sum, m_sum);
        end
    end

    task automatic push(input logic [TW-1:0] v);
        op_valid = 1'b1;
        op_data  = v;
        while (!op_ready) @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!op_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_clear();
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [TW-1:0] neg(input logic [TW-1:0] v);
        return ~v + TW'(1);
    endfunction

    logic [TW-1:0] pool [1024];

    initial begin
        logic [TW-1:0] maxp;
        logic [TW-1:0] minn;
        maxp = {1'b0, {(TW-1){1'b1}}};
        minn = {1'b1, {(TW-1){1'b0}}};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sum == '0, "R1 reset sum", sum, '0);
        chk(!sticky && !done, "R1 reset flags", TW'({sticky, done}), '0);
        chk(op_ready, "R1 reset ready", TW'(op_ready), TW'(1));
        rst_n = 1'b1;
        @(negedge clk);

        // R3: small positives, then a cancelling negative rippling through all words
        push(TW'(5));
        push(TW'(7));
        wait_idle();
        chk(sum == TW'(12), "R3 small adds", sum, TW'(12));
        push(neg(TW'(12)));
        wait_idle();
        chk(sum == '0 && !sticky, "R3 top carry dropped, no R4 overflow", sum, '0);

        // R3: carry from the least significant word into the next
        push(TW'({WW{1'b1}}));
        push(TW'(1));
        wait_idle();
        chk(sum == (TW'(1) << WW), "R3 word carry", sum, TW'(1) << WW);
        push({TW{1'b1}});
        wait_idle();
        chk(sum == TW'({WW{1'b1}}), "R3 minus one", sum, TW'({WW{1'b1}}));
        do_clear();

        // R4/R5: positive overflow, sticky survives a clean add
        push(maxp);
        push(TW'(1));
        wait_idle();
        chk(sticky && sum == minn, "R4 positive overflow", sum, minn);
        push(TW'(3));
        wait_idle();
        chk(sticky, "R5 sticky after clean add", TW'(sticky), TW'(1));
        do_clear();
        chk(!sticky && sum == '0, "R6 clear", sum, '0);

        // R4: negative overflow
        push(minn);
        push({TW{1'b1}});
        wait_idle();
        chk(sticky && sum == maxp, "R4 negative overflow", sum, maxp);
        do_clear();

        // R8: operand offered while busy is ignored
        push(TW'(100));
        op_valid = 1'b1;
        op_data  = TW'(999);
        @(negedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        wait_idle();
        repeat (2) @(negedge clk);
        chk(sum == TW'(100), "R8 busy offer ignored", sum, TW'(100));

        // R6: clear in the middle of an addition abandons it
        push(TW'(77));
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        repeat (NW + 2) @(negedge clk);
        chk(sum == '0, "R6 clear aborts add", sum, '0);

        // R7: 512 values and their negatives in shuffled order cancel exactly
        for (int i = 0; i < 512; i++) begin
            logic [TW-1:0] v;
            v = {64'd0, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            pool[i] = v;
            pool[i + 512] = neg(v);
        end
        for (int i = 1023; i > 0; i--) begin
            int j;
            logic [TW-1:0] t;
            j = $urandom_range(i, 0);
            t = pool[i];
            pool[i] = pool[j];
            pool[j] = t;
        end
        for (int i = 0; i < 1024; i++) push(pool[i]);
        wait_idle();
        chk(sum == '0, "R7 paired sum zero", sum, '0);
        chk(!sticky, "R7 no overflow", TW'(sticky), '0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule